// File: doc/BRIEF.md
# Spread-Symbol Correlation Demodulator

This block turns a stream of sampled, already downconverted baseband chips back into 4-bit data symbols. Every symbol is carried by one of sixteen 32-chip spreading codes. The block holds sixteen correlator arms that run side by side. Each arm multiplies the incoming samples by its own reference code and sums the products over one symbol. A pipelined tree of comparators then picks the arm with the largest sum and reports that arm's index as the decoded symbol.

At a chip rate of 2 Mchip/s this gives 250 kbit/s of data. The block is clocked at the converter's sample rate, so every chip spans `SPC` samples. An upstream timing-recovery stage marks the first sample of each symbol. The `SAMPLE_W` parameter selects the arithmetic: 1 selects single-bit samples with agree/disagree products, and 8 selects 8-bit signed samples with full multiplies.

The input side follows valid/ready rules, but `in_ready` is always high, so the block never pushes back. A sample transfers on any clock edge where `in_valid` is high. The output is a one-cycle `out_valid` pulse with no ready. The consumer must take the symbol in the cycle the pulse is high, and `out_symbol` keeps its value until the next pulse.

Top module: `qo_despreader`

## Requirements
- R1: Code table. Bit c of a 32-bit code word is chip c, and a chip value of 1 is the positive reference. The base word is 32'hB3E20D97. For symbols 0 to 7, chip c of symbol k equals base chip (c - 4k) mod 32. For symbols 8 to 15, the code is that of symbol k-8 with every odd-numbered chip inverted. Chip c covers samples c*SPC to c*SPC+SPC-1 of the symbol.
- R2: With SAMPLE_W=8, each product is the signed sample times +127 when the chip is 1, and times -127 when the chip is 0.
- R3: With SAMPLE_W=1, a sample bit of 1 means positive. A product is +1 when the sample bit equals the chip and -1 when it does not.
- R4: A symbol starts at a transferred sample with `in_sym_start` high and sums exactly 32*SPC transferred samples. Cycles with `in_valid` low are ignored, whatever `in_sym_start` and `in_sample` carry.
- R5: The decoded symbol is the index of the largest of the sixteen sums. When sums are equal, the lower index wins.
- R6: `out_valid` is high for exactly one cycle. It rises on the 5th clock edge counting the edge that transfers the last sample of a symbol as the 1st. `out_symbol` changes only on that edge.
- R7: A start marker that arrives in the middle of a symbol drops the partial sums, and the new symbol begins at that sample.
- R8: Samples transferred after a symbol's last sample and before the next start marker have no effect and produce no output.
- R9: The sums cannot overflow, even when every sample is at full scale.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.
- R11: A symbol whose start marker directly follows the previous symbol's last sample is decoded, and both symbols give one pulse each, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ready | output | 1 | Always high; the block never stalls |
| in_sym_start | input | 1 | Marks the first sample of a symbol |
| in_sample | input | SAMPLE_W | Signed sample (sign bit alone when SAMPLE_W=1) |
| out_valid | output | 1 | One-cycle pulse per decoded symbol |
| out_symbol | output | 4 | Decoded symbol index |

## Verification
The assertions assume that the inputs hold known values from time zero, with `in_valid` low while reset is active, and that a new start marker never lands within five cycles of a previous last sample in a way that would create two pulses in a row. The shortest symbol is 32 samples long, so two pulses are always at least 32 cycles apart. The bench drives only whole samples at falling edges and holds `in_valid` low during reset. Its own gap cycles pair a raised start marker with `in_valid` low, which checks that the marker is ignored without breaking these assumptions.

// File: rtl/qo_pkg.sv
package qo_pkg;
  localparam int NUM_SYM   = 16;
  localparam int SYM_BITS  = 4;
  localparam int CHIPS     = 32;
  localparam int CHIP_SEL_W = 5;
  localparam int ROT_STEP  = 4;
  localparam logic [CHIPS-1:0] BASE_WORD = 32'hB3E2_0D97;
  localparam logic [CHIPS-1:0] ODD_MASK  = 32'hAAAA_AAAA;

  // Code word for symbol k: rotated base, odd chips flipped for the upper half.
  function automatic logic [CHIPS-1:0] code_word(input int k);
    logic [CHIPS-1:0] w;
    int rot;
    rot = (k % 8) * ROT_STEP;
    for (int c = 0; c < CHIPS; c++) begin
      w[CHIP_SEL_W'(c)] = BASE_WORD[CHIP_SEL_W'(c - rot)];
    end
    if (k >= 8) w = w ^ ODD_MASK;
    return w;
  endfunction
endpackage

// File: rtl/qo_arm.sv
module qo_arm
  import qo_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 23,
  parameter int REF_MAG  = 127,
  parameter logic [CHIPS-1:0] CODE = BASE_WORD
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       clr,
  input  logic                       dump,
  input  logic [CHIP_SEL_W-1:0]      chip_sel,
  input  logic [SAMPLE_W-1:0]        sample,
  output logic signed [ACC_W-1:0]    result
);
  logic chip;
  logic signed [ACC_W-1:0] prod, acc, sum;

  assign chip = CODE[chip_sel];

  if (SAMPLE_W == 1) begin : g_bit
    localparam logic signed [ACC_W-1:0] PLUS  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINUS = -PLUS;
    assign prod = (sample[0] == chip) ? PLUS : MINUS;
  end else begin : g_mul
    localparam logic signed [SAMPLE_W-1:0] REF_P = SAMPLE_W'(REF_MAG);
    localparam logic signed [SAMPLE_W-1:0] REF_N = -REF_P;
    logic signed [SAMPLE_W-1:0]   s, r;
    logic signed [2*SAMPLE_W-1:0] p;
    assign s    = signed'(sample);
    assign r    = chip ? REF_P : REF_N;
    assign p    = s * r;
    assign prod = ACC_W'(p);
  end

  assign sum = (clr ? ACC_W'(0) : acc) + prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
    end else if (en) begin
      acc <= sum;
      if (dump) result <= sum;
    end
  end
endmodule

// File: rtl/qo_max_tree.sv
module qo_max_tree #(
  parameter int N = 16,
  parameter int W = 23,
  localparam int LEVELS = $clog2(N),
  localparam int IW = LEVELS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_val [N],
  output logic                out_valid,
  output logic [IW-1:0]       out_idx
);
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = N >> l;
    logic signed [W-1:0] v  [CNT];
    logic [IW-1:0]       ix [CNT];
    logic                vl;
    if (l == 0) begin : g_in
      assign vl = in_valid;
      for (genvar j = 0; j < CNT; j++) begin : g_j
        assign v[j]  = in_val[j];
        assign ix[j] = IW'(j);
      end
    end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vl <= 1'b0;
        else        vl <= g_lvl[l-1].vl;
      end
      for (genvar j = 0; j < CNT; j++) begin : g_j
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v[j]  <= '0;
            ix[j] <= '0;
          end else if (g_lvl[l-1].vl) begin
            // upper entry wins only when strictly larger: ties go to lower index
            if (g_lvl[l-1].v[2*j+1] > g_lvl[l-1].v[2*j]) begin
              v[j]  <= g_lvl[l-1].v[2*j+1];
              ix[j] <= g_lvl[l-1].ix[2*j+1];
            end else begin
              v[j]  <= g_lvl[l-1].v[2*j];
              ix[j] <= g_lvl[l-1].ix[2*j];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= g_lvl[LEVELS-1].vl;
      if (g_lvl[LEVELS-1].vl) begin
        out_idx <= (g_lvl[LEVELS-1].v[1] > g_lvl[LEVELS-1].v[0]) ?
                   g_lvl[LEVELS-1].ix[1] : g_lvl[LEVELS-1].ix[0];
      end
    end
  end
endmodule

// File: rtl/qo_despreader.sv
module qo_despreader
  import qo_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SPC      = 2,
  parameter int REF_MAG  = 127
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sym_start,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SYM_BITS-1:0] out_symbol
);
  localparam int SYM_SAMPLES = CHIPS * SPC;
  localparam int POS_W  = $clog2(SYM_SAMPLES);
  localparam int PROD_W = (SAMPLE_W == 1) ? 2 : 2 * SAMPLE_W;
  localparam int ACC_W  = PROD_W + POS_W + 1;

  logic [POS_W-1:0]      pos, cnt;
  logic                  armed, start, en, last, dump_q;
  logic [CHIP_SEL_W-1:0] chip_sel;
  logic signed [ACC_W-1:0] corr [NUM_SYM];

  assign in_ready = 1'b1;
  assign start    = in_valid & in_sym_start;
  assign en       = in_valid & (start | armed);
  assign cnt      = start ? '0 : pos;
  assign last     = en & (cnt == POS_W'(SYM_SAMPLES - 1));
  assign chip_sel = CHIP_SEL_W'(cnt / POS_W'(SPC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      armed  <= 1'b0;
      dump_q <= 1'b0;
    end else begin
      dump_q <= last;
      if (en) begin
        pos   <= last ? '0 : cnt + 1'b1;
        armed <= !last;
      end
    end
  end

  for (genvar k = 0; k < NUM_SYM; k++) begin : g_arm
    qo_arm #(
      .SAMPLE_W(SAMPLE_W),
      .ACC_W   (ACC_W),
      .REF_MAG (REF_MAG),
      .CODE    (code_word(k))
    ) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .clr     (start),
      .dump    (last),
      .chip_sel(chip_sel),
      .sample  (in_sample),
      .result  (corr[k])
    );
  end

  qo_max_tree #(.N(NUM_SYM), .W(ACC_W)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (dump_q),
    .in_val   (corr),
    .out_valid(out_valid),
    .out_idx  (out_symbol)
  );
endmodule

// File: rtl/qo_despreader_chk.sv
module qo_despreader_chk #(
  parameter int SPC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sym_start,
  input logic       out_valid,
  input logic [3:0] out_symbol,
  input logic       dump_q
);
  localparam int SYM_SAMPLES = 32 * SPC;
  localparam int POS_W = $clog2(SYM_SAMPLES);

  logic [POS_W-1:0] ck_pos, ck_cnt;
  logic ck_armed, ck_go, ck_last;

  assign ck_go   = in_valid & (in_sym_start | ck_armed);
  assign ck_cnt  = (in_valid & in_sym_start) ? '0 : ck_pos;
  assign ck_last = ck_go & (ck_cnt == POS_W'(SYM_SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_pos   <= '0;
      ck_armed <= 1'b0;
    end else if (ck_go) begin
      ck_pos   <= ck_last ? '0 : ck_cnt + 1'b1;
      ck_armed <= !ck_last;
    end
  end

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_last |-> ##5 out_valid);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(ck_last, 5));

  // R4
  dump_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |-> $past(ck_last));

  // R6
  symbol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_symbol));
endmodule

bind qo_despreader qo_despreader_chk #(.SPC(SPC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sym_start(in_sym_start),
  .out_valid   (out_valid),
  .out_symbol  (out_symbol),
  .dump_q      (dump_q)
);

// File: tb/tb_qo_despreader.sv
`timescale 1ns/1ps
module tb_qo_despreader;
  localparam int SPC = 2;
  localparam int SPS = 32 * SPC;
  localparam int REF = 127;
  localparam int NVEC = 10;
  // {sym_a[31:28], amp_a[27:20], sym_b[19:16], amp_b[15:8], 7'b0, gaps[0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0,  8'sd40,   4'd0,  8'sd0,   8'd0},
    {4'd5,  8'sd60,   4'd0,  8'sd0,   8'd1},
    {4'd12, 8'sd30,   4'd3,  8'sd10,  8'd0},
    {4'd15, 8'sd100,  4'd0,  8'sd0,   8'd0},
    {4'd7,  8'sd20,   4'd2,  8'sd20,  8'd0},
    {4'd0,  8'sd0,    4'd0,  8'sd0,   8'd0},
    {4'd10, 8'sd127,  4'd11, -8'sd60, 8'd1},
    {4'd13, 8'sd127,  4'd14, 8'sd127, 8'd0},
    {4'd9,  8'sd127,  4'd0,  8'sd0,   8'd0},
    {4'd6,  -8'sd128, 4'd0,  8'sd0,   8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sym_start = 1'b0;
  logic signed [7:0] smp8 = '0;
  logic smp1;
  logic rdy8, rdy1, ov8, ov1;
  logic [3:0] sym8, sym1;
  int tests = 0, fails = 0;
  int n8 = 0, n1 = 0;
  logic [3:0] hist8 [256];
  logic [3:0] hist1 [256];
  bit done = 0;

  always #2.5 clk = ~clk;
  assign smp1 = ~smp8[7];

  qo_despreader #(.SAMPLE_W(8), .SPC(SPC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
    .in_sym_start(in_sym_start), .in_sample(smp8),
    .out_valid(ov8), .out_symbol(sym8));

  qo_despreader #(.SAMPLE_W(1), .SPC(SPC)) dut1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_sym_start(in_sym_start), .in_sample(smp1),
    .out_valid(ov1), .out_symbol(sym1));

  always @(negedge clk) begin
    if (ov8) begin hist8[n8[7:0]] = sym8; n8 = n8 + 1; end
    if (ov1) begin hist1[n1[7:0]] = sym1; n1 = n1 + 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1 code rule, restated
  function automatic bit tb_chip(int k, int c);
    logic [31:0] w;
    int src;
    bit b;
    w = 32'hB3E20D97;
    src = (((c - 4 * (k % 8)) % 32) + 32) % 32;
    b = w[src];
    if (k >= 8 && (c % 2) == 1) b = ~b;
    return b;
  endfunction

  function automatic int tb_sample(int a, int aa, int b, int ab, int i);
    int c, v;
    c = i / SPC;
    v = aa * (tb_chip(a, c) ? 1 : -1) + ab * (tb_chip(b, c) ? 1 : -1);
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  // R2 R3 R5 model
  function automatic int tb_expect(int a, int aa, int b, int ab, bit one);
    longint best, acc;
    int bi, s;
    bit ch;
    best = 0; bi = 0;
    for (int k = 0; k < 16; k++) begin
      acc = 0;
      for (int i = 0; i < SPS; i++) begin
        s  = tb_sample(a, aa, b, ab, i);
        ch = tb_chip(k, i / SPC);
        if (one) acc += (((s >= 0) ? 1'b1 : 1'b0) == ch) ? 1 : -1;
        else     acc += s * (ch ? REF : -REF);
      end
      if (k == 0 || acc > best) begin best = acc; bi = k; end
    end
    return bi;
  endfunction

  // Drives n samples of a symbol; leaves the last one on the pins.
  task automatic send(int a, int aa, int b, int ab, bit gaps, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sym_start = (i == 0);
      smp8 = 8'(tb_sample(a, aa, b, ab, i));
      if (gaps && (i % 3) == 1 && i != n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sym_start = 1'b1;  // R4: marker without valid must be ignored
        smp8 = 8'sh55;
      end
    end
  endtask

  task automatic idle(int cyc);
    @(negedge clk);
    in_valid = 1'b0; in_sym_start = 1'b0; smp8 = '0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic run_vec(int a, int aa, int b, int ab, bit gaps, string req);
    int b8, b1;
    b8 = n8; b1 = n1;
    send(a, aa, b, ab, gaps, SPS);
    idle(5);
    chk(n8 == b8 + 1, {req, " pulse 8b"}, n8 - b8, 1);
    chk(n1 == b1 + 1, {req, " pulse 1b"}, n1 - b1, 1);
    chk(hist8[b8[7:0]] == 4'(tb_expect(a, aa, b, ab, 1'b0)), {req, " symbol 8b"},
        int'(hist8[b8[7:0]]), tb_expect(a, aa, b, ab, 1'b0));
    chk(hist1[b1[7:0]] == 4'(tb_expect(a, aa, b, ab, 1'b1)), {req, " symbol 1b"},
        int'(hist1[b1[7:0]]), tb_expect(a, aa, b, ab, 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit seen [1:6];
    int b8, b1;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(ov8 == 1'b0 && ov1 == 1'b0, "R10 out_valid in reset", int'(ov8), 0);
    chk(rdy8 == 1'b1 && rdy1 == 1'b1, "R10 in_ready in reset", int'(rdy8), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ov8 == 1'b0, "R10 out_valid after reset", int'(ov8), 0);
    chk(rdy8 == 1'b1, "R10 in_ready after reset", int'(rdy8), 1);

    // vector table: R1 R2 R3 R4 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      run_vec(int'(VEC[v][31:28]), int'(signed'(VEC[v][27:20])),
              int'(VEC[v][19:16]), int'(signed'(VEC[v][15:8])),
              VEC[v][0], $sformatf("R1 R2 R3 R4 R5 R9 vec%0d", v));
    end

    // R6 exact latency
    send(3, 50, 0, 0, 1'b0, SPS);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) begin in_valid = 1'b0; in_sym_start = 1'b0; end
      seen[k] = ov8;
    end
    chk(seen[4] == 1'b0, "R6 low at edge 4", int'(seen[4]), 0);
    chk(seen[5] == 1'b1, "R6 high at edge 5", int'(seen[5]), 1);
    chk(seen[6] == 1'b0, "R6 one cycle", int'(seen[6]), 0);
    chk(hist8[(n8 - 1) & 255] == 4'd3, "R6 symbol", int'(hist8[(n8 - 1) & 255]), 3);
    idle(3);

    // R7 restart mid-symbol
    b8 = n8;
    send(3, 50, 0, 0, 1'b0, 20);
    send(6, 50, 0, 0, 1'b0, SPS);
    idle(5);
    chk(n8 == b8 + 1, "R7 single pulse", n8 - b8, 1);
    chk(hist8[b8[7:0]] == 4'd6, "R7 restarted symbol", int'(hist8[b8[7:0]]), 6);

    // R8 samples after the end without a start marker
    b8 = n8; b1 = n1;
    send(2, 70, 0, 0, 1'b0, SPS);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sym_start = 1'b0;
      smp8 = 8'(tb_sample(9, 90, 0, 0, i % SPS));
    end
    idle(10);
    chk(n8 == b8 + 1, "R8 no extra pulse 8b", n8 - b8, 1);
    chk(n1 == b1 + 1, "R8 no extra pulse 1b", n1 - b1, 1);
    chk(hist8[b8[7:0]] == 4'd2, "R8 symbol", int'(hist8[b8[7:0]]), 2);
    run_vec(8, 45, 0, 0, 1'b0, "R8 next symbol");

    // R11 back-to-back
    b8 = n8;
    send(4, 60, 0, 0, 1'b0, SPS);
    send(11, 60, 0, 0, 1'b0, SPS);
    idle(6);
    chk(n8 == b8 + 2, "R11 two pulses", n8 - b8, 2);
    chk(hist8[b8[7:0]] == 4'd4, "R11 first", int'(hist8[b8[7:0]]), 4);
    chk(hist8[(b8 + 1) & 255] == 4'd11, "R11 second", int'(hist8[(b8 + 1) & 255]), 11);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule